// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

An 8-bit timer/counter with one compare channel that drives a single waveform output. A one-cycle `tick` input stands in for a prescaler: the counter moves only on cycles where `tick` is high. Two mode bits choose one of four counting schemes:

- a free-running up counter (normal);
- an up counter that clears after reaching the compare value (clear-on-compare, CTC);
- a single-slope counter for fast PWM;
- a dual-slope up/down counter for phase-correct PWM.

Two compare-output bits decide how a compare event moves the waveform pin. In both PWM modes the compare value written by software is held in a buffer. It becomes active only when the counter sits at its top value. This keeps the duty cycle from tearing in mid-period.

The control word arrives on a single write strobe and carries the mode, the output behaviour and a force-compare strobe. A forced compare applies the compare-output action at once. It raises no flag and never clears the counter, and it is ignored in the PWM modes.

The phase-correct sequence is run by a two-state direction machine:

- In `DIR_UP`, a tick at 0xFF takes the transition *turn-down*: the next count is 0xFE and the state becomes `DIR_DOWN`.
- In `DIR_DOWN`, a tick at 0x00 takes the transition *turn-up*: the next count is 0x01 and the state becomes `DIR_UP`.
- In any other mode the machine is held in `DIR_UP` (transition *park*).

Top module: `wavetimer8`

## Requirements
- R1: Mode code 00 selects normal and 11 selects fast PWM. In both, each cycle with `tick` high adds one to `count`, wrapping 0xFF to 0x00. Without `tick` the count never changes in any mode.
- R2: Mode code 10 (CTC): a tick while `count` equals the active compare value makes the next count 0x00. Otherwise the count rises by one and wraps past 0xFF.
- R3: Mode code 01 (phase-correct) counts up to 0xFF and then down to 0x00. Each endpoint lasts one tick: after 0xFF comes 0xFE, and after 0x00 on the way down comes 0x01.
- R4: In modes 00 and 10, a compare write is active from the next cycle. In modes 01 and 11, the write only fills a buffer. The buffer value before that edge becomes active on a tick at count 0xFF.
- R5: `ovf_pulse` is high for one cycle after a tick at count 0xFF in modes 00, 10 and 11, and after a tick at count 0x00 in mode 01.
- R6: `match_pulse` is high for one cycle after a tick where `count` equals the active compare value, in every mode.
- R7: In modes 00 and 10, a compare event acts on `wave` according to the output code: 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R8: In fast PWM, output code 10 clears `wave` on a compare event and sets it on a tick at 0xFF. Code 11 does the opposite. When both happen on the same tick, the 0xFF action wins. Codes 00 and 01 leave it unchanged.
- R9: In phase-correct mode, output code 10 clears `wave` on a compare event while in `DIR_UP` and sets it on one while in `DIR_DOWN`. Code 11 does the opposite.
- R10: A control write with the force bit set, whose written mode is 00 or 10, applies the R7 action of the written output code to `wave` on the next cycle. It takes priority over a compare event on the same tick. It raises no `match_pulse` and does not change `count`.
- R11: A control write with the force bit set, whose written mode is 01 or 11, has no effect on `wave`.
- R12: `wave_oe` is high exactly when the stored output code is nonzero. It follows a control write from the next cycle.
- R13: After reset, `count`, `wave`, `wave_oe`, `ovf_pulse` and `match_pulse` are all zero, the mode is normal and the compare value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from an external prescaler |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode code written by `ctl_we` |
| ctl_com | input | 2 | Compare-output code written by `ctl_we` |
| ctl_force | input | 1 | Force-compare strobe, valid with `ctl_we` |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value |
| count | output | 8 | Current counter value |
| wave | output | 1 | Waveform output |
| wave_oe | output | 1 | Waveform overrides the pin's normal function |
| ovf_pulse | output | 1 | One-cycle overflow event |
| match_pulse | output | 1 | One-cycle compare event |

## Verification
The bench builds the block with its default 8-bit counter width. At that width a full up or up/down period takes 256 or 510 ticks, so every wrap, turn-around and top-value buffer load is reached many times in a few thousand cycles. Compare values at both ends (0x00 and 0xFF) bring in the cases where a compare event coincides with the 0xFF action or with a turn-around. Both a constant and a pseudo-random `tick` pattern are used.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PCPWM  = 2'b01,
        MODE_CTC    = 2'b10,
        MODE_FAST   = 2'b11
    } wt_mode_e;

    typedef enum logic [1:0] {
        COM_OFF    = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_CLEAR  = 2'b10,
        COM_SET    = 2'b11
    } wt_com_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_TOGGLE,
        ACT_CLEAR,
        ACT_SET
    } wt_act_e;

    typedef enum logic {
        DIR_UP,
        DIR_DOWN
    } wt_dir_e;

    function automatic logic is_pwm(input wt_mode_e m);
        return (m == MODE_PCPWM) || (m == MODE_FAST);
    endfunction

    // action for a plain compare event in the non-PWM modes
    function automatic wt_act_e com_to_act(input wt_com_e c);
        wt_act_e a;
        unique case (c)
            COM_OFF:    a = ACT_HOLD;
            COM_TOGGLE: a = ACT_TOGGLE;
            COM_CLEAR:  a = ACT_CLEAR;
            COM_SET:    a = ACT_SET;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wt_mode_e     mode,
    input  logic [W-1:0] cmp_active,
    output logic [W-1:0] cnt,
    output wt_dir_e      dir,
    output logic         evt_match,
    output logic         evt_max,
    output logic         evt_ovf
);

    localparam logic [W-1:0] CNT_MAX  = '1;
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

    wt_dir_e      dir_q, dir_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register: direction machine and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= CNT_ZERO;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        cnt_d = cnt_q;
        dir_d = (mode == MODE_PCPWM) ? dir_q : DIR_UP;   // park
        if (tick) begin
            unique case (mode)
                MODE_NORMAL, MODE_FAST: cnt_d = cnt_q + CNT_ONE;
                MODE_CTC: cnt_d = (cnt_q == cmp_active) ? CNT_ZERO : cnt_q + CNT_ONE;
                MODE_PCPWM: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (cnt_q == CNT_MAX) begin       // turn-down
                                cnt_d = CNT_MAX - CNT_ONE;
                                dir_d = DIR_DOWN;
                            end else begin
                                cnt_d = cnt_q + CNT_ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == CNT_ZERO) begin      // turn-up
                                cnt_d = CNT_ONE;
                                dir_d = DIR_UP;
                            end else begin
                                cnt_d = cnt_q - CNT_ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // event outputs
    always_comb begin
        evt_match = tick && (cnt_q == cmp_active);
        evt_max   = tick && (cnt_q == CNT_MAX);
        evt_ovf   = tick && ((mode == MODE_PCPWM) ? (cnt_q == CNT_ZERO) : (cnt_q == CNT_MAX));
    end

    assign cnt = cnt_q;
    assign dir = dir_q;

    p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    p_ctc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_CTC && cnt_q == cmp_active) |=> (cnt_q == CNT_ZERO));

    p_pc_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_PCPWM && dir_q == DIR_UP && cnt_q == CNT_MAX)
        |=> (cnt_q == CNT_MAX - CNT_ONE && dir_q == DIR_DOWN));

    p_pc_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_PCPWM && dir_q == DIR_DOWN && cnt_q == CNT_ZERO)
        |=> (cnt_q == CNT_ONE && dir_q == DIR_UP));

endmodule

// File: rtl/wt_compare.sv
module wt_compare
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm,
    input  logic         load,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_active
);

    logic [W-1:0] buf_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (cmp_we) begin
                buf_q <= cmp_wdata;
            end
            if (cmp_we && !pwm) begin
                act_q <= cmp_wdata;
            end else if (pwm && load) begin
                act_q <= buf_q;
            end
        end
    end

    assign cmp_active = act_q;

    p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load) |=> $stable(act_q));

    p_direct_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !pwm) |=> (act_q == $past(cmp_wdata)));

endmodule

// File: rtl/wt_wave.sv
module wt_wave
    import wt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wt_mode_e mode,
    input  wt_com_e  com,
    input  wt_dir_e  dir,
    input  logic     evt_match,
    input  logic     evt_max,
    input  logic     force_req,
    input  wt_com_e  force_com,
    output logic     wave
);

    wt_act_e act;
    logic    wave_q;

    always_comb begin
        act = ACT_HOLD;
        if (force_req) begin
            act = com_to_act(force_com);
        end else begin
            unique case (mode)
                MODE_NORMAL, MODE_CTC: begin
                    if (evt_match) act = com_to_act(com);
                end
                MODE_FAST: begin
                    if (evt_max) begin
                        if (com == COM_CLEAR)    act = ACT_SET;
                        else if (com == COM_SET) act = ACT_CLEAR;
                    end else if (evt_match) begin
                        if (com == COM_CLEAR)    act = ACT_CLEAR;
                        else if (com == COM_SET) act = ACT_SET;
                    end
                end
                MODE_PCPWM: begin
                    if (evt_match) begin
                        if (com == COM_CLEAR)    act = (dir == DIR_UP) ? ACT_CLEAR : ACT_SET;
                        else if (com == COM_SET) act = (dir == DIR_UP) ? ACT_SET : ACT_CLEAR;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_HOLD:   wave_q <= wave_q;
                ACT_TOGGLE: wave_q <= ~wave_q;
                ACT_CLEAR:  wave_q <= 1'b0;
                ACT_SET:    wave_q <= 1'b1;
            endcase
        end
    end

    assign wave = wave_q;

    p_fast_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_req && mode == MODE_FAST && com == COM_CLEAR && evt_max) |=> wave_q);

    p_force_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && force_com == COM_SET) |=> wave_q);

    p_force_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && force_com == COM_CLEAR) |=> !wave_q);

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctl_we,
    input  logic [1:0]   ctl_mode,
    input  logic [1:0]   ctl_com,
    input  logic         ctl_force,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] count,
    output logic         wave,
    output logic         wave_oe,
    output logic         ovf_pulse,
    output logic         match_pulse
);

    wt_mode_e     mode_q;
    wt_com_e      com_q;
    wt_mode_e     wr_mode;
    wt_com_e      wr_com;
    wt_dir_e      dir;
    logic [W-1:0] cmp_active;
    logic [W-1:0] cnt;
    logic         evt_match, evt_max, evt_ovf;
    logic         force_req;
    logic         ovf_q, match_q;

    assign wr_mode = wt_mode_e'(ctl_mode);
    assign wr_com  = wt_com_e'(ctl_com);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
            com_q  <= COM_OFF;
        end else if (ctl_we) begin
            mode_q <= wr_mode;
            com_q  <= wr_com;
        end
    end

    assign force_req = ctl_we && ctl_force && !is_pwm(wr_mode);

    wt_counter #(.W(W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode       (mode_q),
        .cmp_active (cmp_active),
        .cnt        (cnt),
        .dir        (dir),
        .evt_match  (evt_match),
        .evt_max    (evt_max),
        .evt_ovf    (evt_ovf)
    );

    wt_compare #(.W(W)) u_compare (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm        (is_pwm(mode_q)),
        .load       (evt_max),
        .cmp_we     (cmp_we),
        .cmp_wdata  (cmp_wdata),
        .cmp_active (cmp_active)
    );

    wt_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .com        (com_q),
        .dir        (dir),
        .evt_match  (evt_match),
        .evt_max    (evt_max),
        .force_req  (force_req),
        .force_com  (wr_com),
        .wave       (wave)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            ovf_q   <= evt_ovf;
            match_q <= evt_match;
        end
    end

    assign count       = cnt;
    assign wave_oe     = (com_q != COM_OFF);
    assign ovf_pulse   = ovf_q;
    assign match_pulse = match_q;

    p_ovf_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(tick));

    p_match_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(tick));

    p_pwm_force_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_force && is_pwm(wr_mode) && !tick) |=> $stable(wave));

    p_oe_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (wave_oe == ($past(ctl_com) != 2'b00)));

endmodule

// File: tb/tb_wavetimer8.sv
`timescale 1ns/1ps
module tb_wavetimer8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ctl_we = 1'b0;
    logic [1:0] ctl_mode = 2'b00;
    logic [1:0] ctl_com = 2'b00;
    logic       ctl_force = 1'b0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic [7:0] count;
    logic       wave, wave_oe, ovf_pulse, match_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // tick source: 0 off, 1 always, 2 pseudo-random
    int         tick_src = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    wavetimer8 dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_com(ctl_com), .ctl_force(ctl_force),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .count(count), .wave(wave), .wave_oe(wave_oe),
        .ovf_pulse(ovf_pulse), .match_pulse(match_pulse)
    );

    // ---------------- reference model ----------------
    int m_mode = 0, m_com = 0, m_cnt = 0, m_buf = 0, m_act = 0;
    bit m_up = 1, m_wave = 0, m_ovf = 0, m_match = 0, m_forced = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_com = 0; m_cnt = 0; m_buf = 0; m_act = 0;
            m_up = 1; m_wave = 0; m_ovf = 0; m_match = 0; m_forced = 0;
        end else begin
            bit pwm, ev_match, nw, frc;
            int ncnt, nact;
            bit nup;
            pwm = (m_mode == 1) || (m_mode == 3);
            ev_match = tick && (m_cnt == m_act);
            m_ovf = tick && ((m_mode == 1) ? (m_cnt == 0) : (m_cnt == 255));
            m_match = ev_match;
            nw = m_wave;
            if (tick) begin
                if (m_mode == 0 || m_mode == 2) begin
                    if (ev_match) begin
                        if (m_com == 1) nw = !m_wave;
                        else if (m_com == 2) nw = 0;
                        else if (m_com == 3) nw = 1;
                    end
                end else if (m_mode == 3) begin
                    if (ev_match && m_com == 2) nw = 0;
                    if (ev_match && m_com == 3) nw = 1;
                    if (m_cnt == 255 && m_com == 2) nw = 1;
                    if (m_cnt == 255 && m_com == 3) nw = 0;
                end else begin
                    if (ev_match && m_com == 2) nw = m_up ? 0 : 1;
                    if (ev_match && m_com == 3) nw = m_up ? 1 : 0;
                end
            end
            frc = ctl_we && ctl_force && (ctl_mode == 0 || ctl_mode == 2);
            if (frc) begin
                if (ctl_com == 1) nw = !m_wave;
                else if (ctl_com == 2) nw = 0;
                else if (ctl_com == 3) nw = 1;
                else nw = m_wave;
            end
            m_forced = frc;
            // counter
            ncnt = m_cnt;
            nup = (m_mode == 1) ? m_up : 1'b1;
            if (tick) begin
                case (m_mode)
                    2: ncnt = (m_cnt == m_act) ? 0 : (m_cnt + 1) % 256;
                    1: begin
                        if (m_up) begin
                            if (m_cnt == 255) begin ncnt = 254; nup = 0; end
                            else ncnt = m_cnt + 1;
                        end else begin
                            if (m_cnt == 0) begin ncnt = 1; nup = 1; end
                            else ncnt = m_cnt - 1;
                        end
                    end
                    default: ncnt = (m_cnt + 1) % 256;
                endcase
            end
            // compare register
            nact = m_act;
            if (cmp_we && !pwm) nact = int'(cmp_wdata);
            else if (pwm && tick && m_cnt == 255) nact = m_buf;
            if (cmp_we) m_buf = int'(cmp_wdata);
            m_act = nact;
            m_cnt = ncnt;
            m_up = nup;
            m_wave = nw;
            if (ctl_we) begin
                m_mode = int'(ctl_mode);
                m_com = int'(ctl_com);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string ctag, wtag;
            ctag = (m_mode == 1) ? "R3 count" : (m_mode == 2) ? "R2 count" : "R1 count";
            if (m_forced) wtag = "R10 wave";
            else if (m_mode == 3) wtag = "R8 wave";
            else if (m_mode == 1) wtag = "R9 wave";
            else wtag = "R7 wave";
            check(ctag, int'(count), m_cnt);
            check(wtag, int'(wave), int'(m_wave));
            check("R12 wave_oe", int'(wave_oe), (m_com != 0) ? 1 : 0);
            check("R5 ovf_pulse", int'(ovf_pulse), int'(m_ovf));
            check("R6 R4 match_pulse", int'(match_pulse), int'(m_match));
        end
    end

    // tick driver
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_src)
            1: tick <= 1'b1;
            2: tick <= lfsr[0] | lfsr[3];
            default: tick <= 1'b0;
        endcase
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [1:0] md, input logic [1:0] cm, input logic frc);
        @(negedge clk);
        ctl_we = 1'b1; ctl_mode = md; ctl_com = cm; ctl_force = frc;
        @(negedge clk);
        ctl_we = 1'b0; ctl_force = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0;
        logic w0;
        idle(3);
        // R13 reset state
        check("R13 count", int'(count), 0);
        check("R13 wave", int'(wave), 0);
        check("R13 wave_oe", int'(wave_oe), 0);
        check("R13 ovf_pulse", int'(ovf_pulse), 0);
        check("R13 match_pulse", int'(match_pulse), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // normal mode, toggle on match
        wr_cmp(8'h40);
        wr_ctl(2'b00, 2'b01, 1'b0);
        tick_src = 1; idle(600);
        tick_src = 2; wr_ctl(2'b00, 2'b11, 1'b0); idle(400);
        wr_ctl(2'b00, 2'b00, 1'b0); idle(300);

        // CTC mode
        tick_src = 1;
        wr_cmp(8'h20);
        wr_ctl(2'b10, 2'b01, 1'b0); idle(200);
        wr_cmp(8'h08); idle(100);
        wr_ctl(2'b10, 2'b10, 1'b0); idle(100);
        wr_cmp(8'hFF); idle(600);
        tick_src = 2; wr_cmp(8'h11); wr_ctl(2'b10, 2'b11, 1'b0); idle(300);

        // fast PWM, buffered compare
        tick_src = 1;
        wr_ctl(2'b11, 2'b10, 1'b0);
        wr_cmp(8'h80); idle(300);
        wr_cmp(8'h30); idle(100);
        wr_cmp(8'hFF); idle(600);
        wr_cmp(8'h00); idle(600);
        wr_ctl(2'b11, 2'b11, 1'b0);
        wr_cmp(8'h90); idle(600);
        wr_ctl(2'b11, 2'b01, 1'b0); idle(300);

        // phase-correct PWM
        wr_ctl(2'b01, 2'b10, 1'b0);
        wr_cmp(8'h60); idle(1100);
        wr_cmp(8'hFF); idle(1100);
        wr_cmp(8'h00); idle(1100);
        wr_ctl(2'b01, 2'b11, 1'b0);
        tick_src = 2; wr_cmp(8'hA0); idle(1500);

        // R10: forced compare in CTC, tick held off
        tick_src = 0; idle(2);
        wr_ctl(2'b10, 2'b10, 1'b0);
        wr_cmp(8'h55);
        c0 = int'(count);
        wr_ctl(2'b10, 2'b11, 1'b1);
        check("R10 force set wave", int'(wave), 1);
        check("R10 force no flag", int'(match_pulse), 0);
        check("R10 force keeps count", int'(count), c0);
        wr_ctl(2'b00, 2'b10, 1'b1);
        check("R10 force clear wave", int'(wave), 0);
        wr_ctl(2'b00, 2'b01, 1'b1);
        check("R10 force toggle wave", int'(wave), 1);
        // force on the same tick as a match: force wins
        tick_src = 1; idle(700);
        tick_src = 1; wr_ctl(2'b10, 2'b10, 1'b1); idle(300);

        // R11: force in PWM modes has no effect
        tick_src = 0; idle(2);
        wr_ctl(2'b11, 2'b10, 1'b0);
        w0 = wave;
        wr_ctl(2'b11, 2'b01, 1'b1);
        check("R11 fast force ignored", int'(wave), int'(w0));
        wr_ctl(2'b01, 2'b11, 1'b1);
        check("R11 pc force ignored", int'(wave), int'(w0));
        wr_ctl(2'b01, 2'b00, 1'b0);
        check("R12 oe low", int'(wave_oe), 0);
        idle(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule